// File: doc/BRIEF.md
# Codec Response Ring Writer

This block sits on the controller side of a codec link and stores every response that a codec returns into a circular buffer in system memory. Each response fills one entry of two 32-bit words. The first word is the payload. The second word holds the address of the codec that sent it and a flag that marks the response as unsolicited. The block keeps a hardware write pointer that names the last entry written. Software compares that pointer with its own read pointer to find the new entries.

Software programs a threshold N. After N new entries the block sets a sticky status bit, and software clears that bit by writing one to it. The interrupt line is that status bit gated by an interrupt enable. A run enable opens the block to traffic. When software clears it, the run indication stays high until the response in flight has been fully written, so software can poll for the point where the buffer is quiet.

Top module: `resp_ring_writer`

## Requirements
- R1: After reset, `wr_ptr_o` is 0, `sts_o` and `irq_o` are 0, `run_o` is 0 and no memory write is issued.
- R2: `resp_ready_o` is high only while `dma_en_i` is 1 and no earlier response is still being written. A response is taken on a cycle where `resp_valid_i` and `resp_ready_o` are both high.
- R3: The pointer is advanced before the store. A response accepted while the pointer is P is written to entry (P+1) mod 256. The first response after a pointer reset therefore lands in entry 1. After the write, `wr_ptr_o` reads (P+1) mod 256.
- R4: An entry at index E occupies dword addresses 2E and 2E+1.
  - The payload goes to 2E, in the cycle right after acceptance.
  - The extended word goes to 2E+1, in the following cycle.
  - The extended word carries the codec address in bits 3:0 and the unsolicited flag in bit 4. All other bits are zero.
- R5: A pulse on `wr_ptr_rst_i` returns `wr_ptr_o` to 0. It also clears the count of entries since the last status event.
- R6: `sts_o` becomes 1 in the cycle in which the Nth new entry is committed, where N is `int_cnt_i`. The value 0 stands for 256. The entry count then restarts from zero, so N=1 sets the status on every entry.
- R7: `sts_o` is sticky. A pulse on `sts_clr_i` clears it. A new status event in the same cycle as the clear wins.
- R8: `irq_o` equals `sts_o` AND `irq_en_i`.
- R9: `run_o` is 1 while `dma_en_i` is 1 or an accepted response has not finished writing. Clearing `dma_en_i` in the middle of a write keeps `run_o` at 1 until the second word is written.
- R10: While `dma_en_i` is 0, no response is accepted, no write occurs and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| resp_valid_i | input | 1 | A response is offered |
| resp_ready_o | output | 1 | The block can take a response |
| resp_data_i | input | 32 | Response payload |
| resp_cad_i | input | 4 | Address of the sending codec |
| resp_unsol_i | input | 1 | Response is unsolicited |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 9 | Dword index within the ring |
| mem_wdata_o | output | 32 | Memory write data |
| wr_ptr_rst_i | input | 1 | Pulse: reset the write pointer |
| wr_ptr_o | output | 8 | Index of the last entry written |
| int_cnt_i | input | 8 | Entries per status event (0 means 256) |
| dma_en_i | input | 1 | Run enable |
| run_o | output | 1 | Run read-back, held high until the writer drains |
| irq_en_i | input | 1 | Interrupt enable |
| sts_clr_i | input | 1 | Pulse: clear the status bit |
| sts_o | output | 1 | Sticky response status |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions assume that `wr_ptr_rst_i` is pulsed only while the writer is idle. They also assume that `int_cnt_i` holds steady while responses are in flight. The bench keeps to both by resetting the pointer and changing the threshold only between responses. It clears the status after each event and then sends more than a full ring of responses under several thresholds, including 0. Each memory word, the pointer and the status are compared with values the bench computes arithmetically.

// File: rtl/resp_ring_pkg.sv
package resp_ring_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } wr_state_e;

  localparam int unsigned EXT_W = 32;

  // extended dword: address in low nibble, unsolicited flag above it
  function automatic logic [EXT_W-1:0] pack_ext(input logic [3:0] cad, input logic unsol);
    pack_ext = '0;
    pack_ext[3:0] = cad;
    pack_ext[4]   = unsol;
  endfunction
endpackage

// File: rtl/resp_ring_ptr.sv
module resp_ring_ptr #(
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptr_rst_i,
  input  logic             step_i,
  input  logic [PTR_W-1:0] thresh_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] ptr_nxt_o,
  output logic             hit_o
);
  logic [PTR_W-1:0] ptr_q, cnt_q;
  logic [PTR_W-1:0] cnt_inc;

  assign ptr_nxt_o = ptr_q + 1'b1;
  assign cnt_inc   = cnt_q + 1'b1;
  // threshold 0 wraps naturally to full ring count
  assign hit_o     = step_i && !ptr_rst_i && (cnt_inc == thresh_i);
  assign ptr_o     = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (ptr_rst_i) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (step_i) begin
      ptr_q <= ptr_nxt_o;
      cnt_q <= hit_o ? '0 : cnt_inc;
    end
  end
endmodule

// File: rtl/resp_ring_sts.sv
module resp_ring_sts (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic sts_o,
  output logic irq_o
);
  logic sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sts_q <= 1'b0;
    else if (set_i)  sts_q <= 1'b1;
    else if (clr_i)  sts_q <= 1'b0;
  end

  assign sts_o = sts_q;
  assign irq_o = sts_q & irq_en_i;
endmodule

// File: rtl/resp_ring_writer.sv
module resp_ring_writer
  import resp_ring_pkg::*;
#(
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CAD_W  = 4,
  localparam int unsigned ADDR_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              resp_valid_i,
  output logic              resp_ready_o,
  input  logic [DATA_W-1:0] resp_data_i,
  input  logic [CAD_W-1:0]  resp_cad_i,
  input  logic              resp_unsol_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              wr_ptr_rst_i,
  output logic [PTR_W-1:0]  wr_ptr_o,
  input  logic [PTR_W-1:0]  int_cnt_i,
  input  logic              dma_en_i,
  output logic              run_o,
  input  logic              irq_en_i,
  input  logic              sts_clr_i,
  output logic              sts_o,
  output logic              irq_o
);
  wr_state_e         st_q;
  logic [DATA_W-1:0] data_q;
  logic [CAD_W-1:0]  cad_q;
  logic              unsol_q;
  logic              accept, commit, hit;
  logic [PTR_W-1:0]  ptr_nxt;
  logic [3:0]        cad_n;

  assign resp_ready_o = dma_en_i && (st_q == ST_IDLE);
  assign accept       = resp_valid_i && resp_ready_o;
  assign commit       = (st_q == ST_HI);
  assign run_o        = dma_en_i || (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      data_q  <= '0;
      cad_q   <= '0;
      unsol_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= ST_LO;
          data_q  <= resp_data_i;
          cad_q   <= resp_cad_i;
          unsol_q <= resp_unsol_i;
        end
        ST_LO:   st_q <= ST_HI;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  generate
    if (CAD_W >= 4) begin : g_cad_trunc
      assign cad_n = cad_q[3:0];
    end else begin : g_cad_pad
      assign cad_n = {{(4-CAD_W){1'b0}}, cad_q};
    end
  endgenerate

  always_comb begin
    mem_we_o    = (st_q == ST_LO) || (st_q == ST_HI);
    mem_addr_o  = {ptr_nxt, (st_q == ST_HI)};
    mem_wdata_o = (st_q == ST_HI) ? DATA_W'(pack_ext(cad_n, unsol_q)) : data_q;
  end

  resp_ring_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ptr_rst_i (wr_ptr_rst_i),
    .step_i    (commit),
    .thresh_i  (int_cnt_i),
    .ptr_o     (wr_ptr_o),
    .ptr_nxt_o (ptr_nxt),
    .hit_o     (hit)
  );

  resp_ring_sts u_sts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (hit),
    .clr_i    (sts_clr_i),
    .irq_en_i (irq_en_i),
    .sts_o    (sts_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/resp_ring_writer_chk.sv
module resp_ring_writer_chk #(
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned ADDR_W = PTR_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              resp_valid_i,
  input logic              resp_ready_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              wr_ptr_rst_i,
  input logic [PTR_W-1:0]  wr_ptr_o,
  input logic              dma_en_i,
  input logic              run_o,
  input logic              irq_en_i,
  input logic              sts_clr_i,
  input logic              sts_o,
  input logic              irq_o
);
  // R2
  ready_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_ready_o |-> dma_en_i && !mem_we_o);

  // R4
  lo_then_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mem_addr_o[0]) |=> (mem_we_o && mem_addr_o[0]));

  // R3
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ptr_rst_i && mem_we_o && mem_addr_o[0]) |=> (wr_ptr_o == $past(mem_addr_o[ADDR_W-1:1])));

  // R5
  ptr_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ptr_rst_i |=> (wr_ptr_o == '0));

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (sts_o && irq_en_i));

  // R9
  run_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> run_o);

  // R7
  sts_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o && !sts_clr_i) |=> sts_o);

  // R10
  idle_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_en_i && !run_o) |=> !mem_we_o);
endmodule

bind resp_ring_writer resp_ring_writer_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .resp_valid_i (resp_valid_i),
  .resp_ready_o (resp_ready_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .wr_ptr_rst_i (wr_ptr_rst_i),
  .wr_ptr_o     (wr_ptr_o),
  .dma_en_i     (dma_en_i),
  .run_o        (run_o),
  .irq_en_i     (irq_en_i),
  .sts_clr_i    (sts_clr_i),
  .sts_o        (sts_o),
  .irq_o        (irq_o)
);

// File: tb/sim_resp_ring_writer.sv
module sim_resp_ring_writer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, ready;
  logic [31:0] data = '0;
  logic [3:0]  cad = '0;
  logic        unsol = 1'b0;
  logic        we;
  logic [8:0]  addr;
  logic [31:0] wdata;
  logic        ptr_rst = 1'b0;
  logic [7:0]  wp;
  logic [7:0]  n_cnt = 8'd1;
  logic        dma_en = 1'b0, run;
  logic        irq_en = 1'b0, sts_clr = 1'b0, sts, irq;

  int tests = 0, fails = 0;
  int exp_wp = 0, exp_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resp_ring_writer u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .resp_valid_i(valid), .resp_ready_o(ready),
    .resp_data_i(data), .resp_cad_i(cad), .resp_unsol_i(unsol),
    .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .wr_ptr_rst_i(ptr_rst), .wr_ptr_o(wp), .int_cnt_i(n_cnt),
    .dma_en_i(dma_en), .run_o(run), .irq_en_i(irq_en),
    .sts_clr_i(sts_clr), .sts_o(sts), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_sts();
    @(negedge clk); sts_clr = 1'b1;
    @(negedge clk); sts_clr = 1'b0;
    chk("R7 clear", {31'b0, sts}, 32'd0);
  endtask

  // expects the writer idle and enabled
  task automatic send(input logic [31:0] d, input logic [3:0] c, input logic u);
    int th;
    @(negedge clk);
    chk("R2 ready", {31'b0, ready}, 32'd1);
    valid = 1'b1; data = d; cad = c; unsol = u;
    @(negedge clk);
    valid = 1'b0;
    exp_wp = (exp_wp + 1) % 256;
    chk("R4 lo we", {31'b0, we}, 32'd1);
    chk("R3 lo addr", {23'b0, addr}, 32'(exp_wp * 2));
    chk("R4 lo data", wdata, d);
    chk("R2 busy", {31'b0, ready}, 32'd0);
    @(negedge clk);
    chk("R4 hi addr", {23'b0, addr}, 32'(exp_wp * 2 + 1));
    chk("R4 ext", wdata, {27'b0, u, c});
    @(negedge clk);
    chk("R3 wp", {24'b0, wp}, 32'(exp_wp));
    chk("R4 done", {31'b0, we}, 32'd0);
    th = (n_cnt == 0) ? 256 : int'(n_cnt);
    exp_cnt++;
    if (exp_cnt == th) begin
      exp_cnt = 0;
      chk("R6 set", {31'b0, sts}, 32'd1);
      chk("R8 irq", {31'b0, irq}, {31'b0, irq_en});
      clear_sts();
      chk("R8 irq low", {31'b0, irq}, 32'd0);
    end else begin
      chk("R6 quiet", {31'b0, sts}, 32'd0);
    end
  endtask

  task automatic ptr_reset();
    @(negedge clk); ptr_rst = 1'b1;
    @(negedge clk); ptr_rst = 1'b0;
    exp_wp = 0; exp_cnt = 0;
    chk("R5 ptr", {24'b0, wp}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 wp", {24'b0, wp}, 32'd0);
    chk("R1 sts", {30'b0, sts, irq}, 32'd0);
    chk("R1 run", {30'b0, run, we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: disabled, offered response must be ignored
    valid = 1'b1; data = 32'hdead_beef;
    repeat (3) @(negedge clk);
    chk("R10 ready", {31'b0, ready}, 32'd0);
    chk("R10 we", {31'b0, we}, 32'd0);
    chk("R10 wp", {24'b0, wp}, 32'd0);
    valid = 1'b0;
    dma_en = 1'b1; irq_en = 1'b1;
    // R6 sweep: thresholds 1..4 and 0 (=256), wrap past the ring end
    for (int n = 1; n <= 4; n++) begin
      n_cnt = 8'(n);
      ptr_reset();
      for (int i = 0; i < 3 * n + 1; i++)
        send(32'h1000_0000 * n + i, 4'(i), 1'(i % 2));
    end
    irq_en = 1'b0;
    n_cnt = 8'd0;
    ptr_reset();
    for (int i = 0; i < 300; i++)
      send(32'ha5a5_0000 ^ i, 4'(i * 3), 1'(i / 7 % 2));
    // R7: set beats clear
    n_cnt = 8'd1; irq_en = 1'b1;
    ptr_reset();
    @(negedge clk); valid = 1'b1; data = 32'h7; cad = 4'h2; unsol = 1'b0;
    @(negedge clk); valid = 1'b0;
    @(negedge clk); sts_clr = 1'b1;
    @(negedge clk); sts_clr = 1'b0;
    chk("R7 set wins", {31'b0, sts}, 32'd1);
    clear_sts();
    exp_wp = 1;
    // R9: drop enable mid-write
    @(negedge clk); valid = 1'b1; data = 32'h55;
    @(negedge clk); valid = 1'b0; dma_en = 1'b0;
    chk("R9 run lo", {31'b0, run}, 32'd1);
    @(negedge clk);
    chk("R9 run hi", {31'b0, run}, 32'd1);
    chk("R9 hi write", {31'b0, we}, 32'd1);
    @(negedge clk);
    chk("R9 drained", {31'b0, run}, 32'd0);
    chk("R10 wp after", {24'b0, wp}, 32'd2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule